// File: doc/BRIEF.md
# Transmit Frame Terminator with Abort and FCS Corruption

This block sits in a byte-wide transmit path. It passes payload bytes through one register stage and keeps a running Ethernet CRC-32 over them. When the upstream source marks the final byte, the block appends the four-byte frame check sequence right after it. An abort strobe can end a frame early.

How an aborted frame ends depends on how much of it has already been sent. If fewer than 512 bits have been accepted, the frame stops at once and leaves a runt. Once 512 bits or more have been accepted, the block sends the byte presented in the abort cycle, if there is one. It then appends the CRC register without the final complement. The receiver is therefore certain to see a check failure. In every case a one-cycle `done` pulse marks the end of the frame. The block does not handle preamble, medium access or retries.

Top module: `tx_fcs_abort`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `done` are low.
- R2: A byte accepted with `in_valid` shows up on `out_data` with `out_valid` on the next cycle. Byte order and values are kept.
- R3: The check value is CRC-32 with generator 0x04C11DB7, processed least significant bit first (reflected constant 0xEDB88320), with the register set to all ones at the start of a frame. On a normal end (`in_last`), the complement of the register is sent as four bytes, least significant byte first, on the four cycles directly after the last payload byte. `out_last` is high with the fourth of these bytes.
- R4: An abort raised while fewer than 64 bytes (512 bits) have been accepted before that cycle drops any byte offered in the same cycle. No further `out_valid` follows, and `out_last` is never raised for that frame.
- R5: An abort raised once 64 or more bytes have been accepted works as follows. A byte offered in the same cycle is sent. The four cycles directly after the last payload byte then carry the uncomplemented CRC register, least significant byte first, with `out_last` on the fourth.
- R6: `done` pulses for exactly one cycle when a frame ends. It comes with the last check byte for R3 and R5. It comes in the cycle after the abort, with `out_valid` low, for R4.
- R7: Input bytes and aborts presented while check bytes are being appended are ignored. The next frame starts from a fresh CRC and a fresh length count.
- R8: An abort raised while no frame is in progress is ignored. It produces no output and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Payload byte from the source |
| in_valid | input | 1 | `in_data` carries a byte this cycle |
| in_last | input | 1 | This byte ends the payload |
| abort_req | input | 1 | Request to end the current frame early |
| out_data | output | 8 | Byte toward the line |
| out_valid | output | 1 | `out_data` carries a byte |
| out_last | output | 1 | Final byte of the frame |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A corrupted CRC register cannot be seen while payload is flowing. It first shows up in the four check bytes, which come one to four cycles after the last payload byte. The bench therefore compares every check byte against a bench-computed CRC, including the known result for the ASCII string "123456789". An error in the length count shows only in the choice between runt and corrupted tail, so aborts are placed at 63 and 64 bytes on either side of the threshold. A wrong state-machine state shows within one cycle: as a missing or extra `out_valid`, a stray `done`, or bytes accepted while the tail is being sent.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_TAIL = 2'd2
  } tfa_state_t;
endpackage

// File: rtl/tfa_crc_step.sv
// One byte of reflected CRC update, unrolled bit by bit.
module tfa_crc_step #(
  parameter int          CRC_W    = 32,
  parameter int          DATA_W   = 8,
  parameter logic [31:0] POLY_REF = 32'hEDB88320
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  always_comb begin
    logic [CRC_W-1:0] c;
    c = crc_in;
    for (int b = 0; b < DATA_W; b++) begin
      if (c[0] ^ data_in[b]) c = (c >> 1) ^ POLY_REF[CRC_W-1:0];
      else                   c = c >> 1;
    end
    crc_out = c;
  end
endmodule

// File: rtl/tfa_len_counter.sv
// Saturating count of accepted bytes; flags the 512-bit threshold.
module tfa_len_counter #(
  parameter int MIN_BITS = 512,
  parameter int DATA_W   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic incr,
  output logic past_min
);
  localparam int MIN_BYTES = MIN_BITS / DATA_W;
  localparam int CW        = $clog2(MIN_BYTES + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_BYTES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)              cnt <= '0;
    else if (incr && cnt != SAT)   cnt <= cnt + 1'b1;
  end

  assign past_min = (cnt == SAT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= SAT);  // R5
endmodule

// File: rtl/tx_fcs_abort.sv
module tx_fcs_abort #(
  parameter int DATA_W   = 8,
  parameter int CRC_W    = 32,
  parameter int MIN_BITS = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              abort_req,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_last,
  output logic              done
);
  import tfa_pkg::*;

  localparam int FCS_BYTES = CRC_W / DATA_W;
  localparam int IDXW      = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
  localparam logic [IDXW-1:0] IDX_LAST = IDXW'(FCS_BYTES - 1);

  tfa_state_t       state;
  logic [CRC_W-1:0] crc, crc_nxt, tail_word;
  logic [IDXW-1:0]  idx;
  logic             corrupt;
  logic             past_min;
  logic             take_byte, runt_abort, cnt_clear;

  tfa_crc_step #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_crc (
    .crc_in (crc),
    .data_in(in_data),
    .crc_out(crc_nxt)
  );

  assign runt_abort = (state == ST_DATA) && abort_req && !past_min;
  assign take_byte  = in_valid && ((state == ST_IDLE) ||
                      (state == ST_DATA && !runt_abort));
  assign cnt_clear  = (state == ST_TAIL) || runt_abort;

  tfa_len_counter #(.MIN_BITS(MIN_BITS), .DATA_W(DATA_W)) u_len (
    .clk     (clk),
    .rst     (rst),
    .clear   (cnt_clear),
    .incr    (take_byte),
    .past_min(past_min)
  );

  assign tail_word = corrupt ? crc : ~crc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      crc       <= '1;
      idx       <= '0;
      corrupt   <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      if (take_byte) begin
        out_data  <= in_data;
        out_valid <= 1'b1;
        crc       <= crc_nxt;
      end
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            idx     <= '0;
            corrupt <= 1'b0;
            state   <= in_last ? ST_TAIL : ST_DATA;
          end
        end
        ST_DATA: begin
          if (abort_req) begin
            if (past_min) begin
              idx     <= '0;
              corrupt <= 1'b1;
              state   <= ST_TAIL;
            end else begin
              crc   <= '1;
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end else if (in_valid && in_last) begin
            idx     <= '0;
            corrupt <= 1'b0;
            state   <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          out_valid <= 1'b1;
          out_data  <= tail_word[idx*DATA_W +: DATA_W];
          idx       <= idx + 1'b1;
          if (idx == IDX_LAST) begin
            out_last <= 1'b1;
            done     <= 1'b1;
            crc      <= '1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_valid && done));  // R3
  AST_RUNT_STOP: assert property (@(posedge clk) disable iff (rst)
    runt_abort |=> (done && !out_valid && !out_last));  // R4
  AST_TAIL_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAIL) |=> out_valid);  // R5
  AST_IDLE_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && abort_req && !in_valid) |=> (!out_valid && !done));  // R8
  AST_TAIL_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAIL && in_valid) |-> !take_byte);  // R7
endmodule

// File: tb/tx_fcs_abort_bench.sv
module tx_fcs_abort_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_last = 1'b0, abort_req = 1'b0;
  logic [7:0] out_data;
  logic       out_valid, out_last, done;

  int checks = 0, errors = 0;
  logic [7:0] cap [0:255];
  logic [7:0] expv [0:255];
  int ncap = 0, nexp = 0, nlast = 0, ndone = 0, last_pos = -1, done_pos = -1;
  logic mon_on = 1'b0;

  always #5 clk = ~clk;

  tx_fcs_abort u_tx_fcs_abort (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .abort_req(abort_req), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .done(done)
  );

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        cap[ncap] = out_data;
        ncap = ncap + 1;
      end
      if (out_last) begin
        nlast = nlast + 1;
        last_pos = ncap - 1;
      end
      if (done) begin
        ndone = ndone + 1;
        done_pos = out_valid ? ncap - 1 : -2;
      end
    end
  end

  function automatic logic [31:0] crc_upd(logic [31:0] c, logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++)
      r = ((r ^ {31'd0, d[i]}) & 32'd1) != 0 ? (r >> 1) ^ 32'hEDB88320 : r >> 1;
    return r;
  endfunction

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 37 + i * 13 + (i >> 3)) & 8'hFF);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    ncap = 0; nexp = 0; nlast = 0; ndone = 0; last_pos = -1; done_pos = -1;
  endtask

  task automatic add_fcs(logic [31:0] word);
    for (int k = 0; k < 4; k++) begin
      expv[nexp] = word[k*8 +: 8];
      nexp++;
    end
  endtask

  task automatic compare(string req, int exp_last, int exp_done_pos);
    chk(ncap == nexp, req, "byte count", ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++)
      chk(cap[i] == expv[i], req, $sformatf("byte %0d", i), cap[i], expv[i]);
    chk(nlast == exp_last, req, "out_last count", nlast, exp_last);
    if (exp_last == 1) chk(last_pos == nexp - 1, req, "out_last position", last_pos, nexp - 1);
    chk(ndone == 1, req, "done count", ndone, 1);
    chk(done_pos == exp_done_pos, req, "done position", done_pos, exp_done_pos);
  endtask

  task automatic push(logic [7:0] d, bit last, bit ab);
    @(negedge clk);
    in_data = d; in_valid = 1'b1; in_last = last; abort_req = ab;
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; abort_req = 1'b0;
  endtask

  // Normal frame: R2 pass-through and R3 good FCS
  task automatic t_normal(int n, int seed);
    logic [31:0] c = '1;
    mon_clear();
    for (int i = 0; i < n; i++) begin
      expv[nexp] = pat(seed, i); nexp++;
      c = crc_upd(c, pat(seed, i));
      push(pat(seed, i), i == n - 1, 1'b0);
    end
    idle_inputs();
    repeat (8) @(negedge clk);
    add_fcs(~c);
    compare("R2/R3", 1, nexp - 1);
  endtask

  // Known vector "123456789" -> CRC 0xCBF43926 (R3)
  task automatic t_known();
    string s = "123456789";
    mon_clear();
    for (int i = 0; i < 9; i++) begin
      expv[nexp] = s[i]; nexp++;
      push(s[i], i == 8, 1'b0);
    end
    idle_inputs();
    repeat (8) @(negedge clk);
    add_fcs(32'hCBF43926);
    compare("R3", 1, nexp - 1);
  endtask

  // Abort after n bytes, optionally with a byte in the abort cycle (R4/R5)
  task automatic t_abort(int n, bit with_byte, int seed);
    logic [31:0] c = '1;
    bit long_f = (n >= 64);
    mon_clear();
    for (int i = 0; i < n; i++) begin
      expv[nexp] = pat(seed, i); nexp++;
      c = crc_upd(c, pat(seed, i));
      push(pat(seed, i), 1'b0, 1'b0);
    end
    @(negedge clk);
    in_valid = with_byte; in_data = pat(seed, n); in_last = 1'b0; abort_req = 1'b1;
    if (with_byte && long_f) begin
      expv[nexp] = pat(seed, n); nexp++;
      c = crc_upd(c, pat(seed, n));
    end
    idle_inputs();
    repeat (8) @(negedge clk);
    if (long_f) begin
      add_fcs(c);
      compare("R5", 1, nexp - 1);
    end else begin
      compare("R4", 0, -2);
    end
  endtask

  // Input and abort during tail are ignored, then a fresh frame (R7)
  task automatic t_tail_ignore();
    logic [31:0] c = '1;
    mon_clear();
    for (int i = 0; i < 5; i++) begin
      expv[nexp] = pat(7, i); nexp++;
      c = crc_upd(c, pat(7, i));
      push(pat(7, i), i == 4, 1'b0);
    end
    for (int j = 0; j < 4; j++) push(8'hA5, j == 1, j == 2);
    idle_inputs();
    repeat (8) @(negedge clk);
    add_fcs(~c);
    compare("R7", 1, nexp - 1);
    t_normal(6, 9);
  endtask

  // Abort while idle (R8)
  task automatic t_idle_abort();
    mon_clear();
    @(negedge clk);
    abort_req = 1'b1;
    idle_inputs();
    repeat (6) @(negedge clk);
    chk(ncap == 0, "R8", "bytes after idle abort", ncap, 0);
    chk(ndone == 0, "R8", "done after idle abort", ndone, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(out_last == 1'b0, "R1", "out_last in reset", out_last, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R1", "outputs after reset", {out_valid, done}, 0);
    t_normal(10, 1);
    t_known();
    t_normal(1, 3);
    t_abort(20, 1'b0, 2);
    t_abort(63, 1'b1, 4);
    t_abort(64, 1'b0, 5);
    t_abort(70, 1'b1, 6);
    t_idle_abort();
    t_normal(12, 8);
    t_tail_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule